// File: doc/BRIEF.md
# Aligned Circular and Bit-Reversed Pointer Unit

This block is the address arithmetic for single-operand indirect memory accesses. It keeps eight pointer registers of `AW` bits, of which pointer 0 also serves as the index (step) register, and one buffer-length register. On each access the caller names a pointer and an update code. The unit returns the memory address one cycle later and writes the updated value back into the pointer.

Circular updates need no start-address register. The buffer occupies a block whose size is the smallest power of two that can hold the length, counting the length's most significant set bit. The start is the pointer with every bit up to and including that bit position cleared. Stepping past either end of the buffer wraps, so the first and last words behave as neighbours. Bit-reversed updates add or subtract the index with carries that travel from the most significant bit toward the least. With the index at half the transform size, this walks an FFT buffer in reversed order.

Loads come in on a separate write port that is sampled at the same clock edge as accesses.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset, all pointers, the index and the length register read as 0, and `addr_vld` is low.
- R2: `ld_en` writes `ld_data` into pointer `ld_sel` for codes 0 to 7, and into the length register for code 8. If a load and an access update target the same pointer in the same cycle, the load is kept.
- R3: `addr_vld` is high, and `addr_out` carries the address, exactly one cycle after a cycle with `acc_en` high. Otherwise `addr_vld` is low. Every update code except 11 and 12 outputs the pointer value as it was before the update.
- R4: Linear codes wrap modulo 2^AW. Code 1 adds 1, code 2 subtracts 1, code 3 adds the index, and code 4 subtracts the index.
- R5: Circular codes are 5 (+1), 6 (−1), 7 (+index) and 8 (−index). Let L be the buffer length, and let m be the mask of all bits at or below the most significant set bit of L. The new pointer is (p & ~m) + ((p & m) ± step) mod L. For example, L=30 clears 5 bits and L=32 clears 6 bits.
- R6: For circular codes, the index is taken as a signed value, so a negative index reverses the direction. A step of L or more is reduced modulo L. A pointer inside its buffer stays inside the same buffer.
- R7: When L is 0, the circular codes behave exactly like the matching linear codes (5→1, 6→2, 7→3, 8→4).
- R8: Code 9 adds the index and code 10 subtracts it, with carries propagating from the MSB toward the LSB (reverse the bits, add or subtract, then reverse the result).
- R9: Code 11 outputs p + `acc_k` and leaves the pointer unchanged. Code 12 outputs p + `acc_k` and also writes that sum back into the pointer.
- R10: Code 0, and the unused codes 13, 14 and 15, output p and leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | SELW+1 | Load target: 0..NPTR-1 pointer, NPTR length register |
| ld_data | input | AW | Load value |
| acc_en | input | 1 | Access request |
| acc_sel | input | SELW | Pointer used by the access |
| acc_op | input | 4 | Update code (see R3–R10) |
| acc_k | input | AW | Constant offset for codes 11 and 12 |
| addr_out | output | AW | Address of the last access |
| addr_vld | output | 1 | `addr_out` holds a new address |

## Verification
The bench builds the unit with its defaults, AW=16 and NPTR=8. At that width a pointer can step across 0xFFFF to 0, a length of 32 needs a 64-word block, and a signed index of 0xFFFE is a genuine backward step. Directed sequences cover buffer lengths of 30, 32 and 0, an index larger than the length, a full 16-point bit-reversed walk, and a load racing an update. A long pseudo-random phase then keeps circular traffic on pointers 4 to 7 inside their buffers, mixes every other code on pointers 1 to 3, and checks every cycle against a behavioural integer model.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

    localparam logic [3:0] OP_KEEP   = 4'd0;
    localparam logic [3:0] OP_INC    = 4'd1;
    localparam logic [3:0] OP_DEC    = 4'd2;
    localparam logic [3:0] OP_ADDX   = 4'd3;
    localparam logic [3:0] OP_SUBX   = 4'd4;
    localparam logic [3:0] OP_CINC   = 4'd5;
    localparam logic [3:0] OP_CDEC   = 4'd6;
    localparam logic [3:0] OP_CADDX  = 4'd7;
    localparam logic [3:0] OP_CSUBX  = 4'd8;
    localparam logic [3:0] OP_BADD   = 4'd9;
    localparam logic [3:0] OP_BSUB   = 4'd10;
    localparam logic [3:0] OP_OFS    = 4'd11;
    localparam logic [3:0] OP_PREOFS = 4'd12;

    typedef enum logic [2:0] {
        UPD_NONE,
        UPD_LIN,
        UPD_CIRC,
        UPD_BREV,
        UPD_OFS
    } upd_kind_e;

    typedef struct packed {
        upd_kind_e kind;
        logic      neg;
        logic      use_idx;
        logic      wb;
    } upd_ctl_t;

    function automatic upd_ctl_t decode_op(input logic [3:0] op);
        upd_ctl_t c;
        c.kind    = UPD_NONE;
        c.neg     = 1'b0;
        c.use_idx = 1'b0;
        c.wb      = 1'b0;
        case (op)
            OP_INC:    begin c.kind = UPD_LIN;  c.wb = 1'b1; end
            OP_DEC:    begin c.kind = UPD_LIN;  c.wb = 1'b1; c.neg = 1'b1; end
            OP_ADDX:   begin c.kind = UPD_LIN;  c.wb = 1'b1; c.use_idx = 1'b1; end
            OP_SUBX:   begin c.kind = UPD_LIN;  c.wb = 1'b1; c.use_idx = 1'b1; c.neg = 1'b1; end
            OP_CINC:   begin c.kind = UPD_CIRC; c.wb = 1'b1; end
            OP_CDEC:   begin c.kind = UPD_CIRC; c.wb = 1'b1; c.neg = 1'b1; end
            OP_CADDX:  begin c.kind = UPD_CIRC; c.wb = 1'b1; c.use_idx = 1'b1; end
            OP_CSUBX:  begin c.kind = UPD_CIRC; c.wb = 1'b1; c.use_idx = 1'b1; c.neg = 1'b1; end
            OP_BADD:   begin c.kind = UPD_BREV; c.wb = 1'b1; c.use_idx = 1'b1; end
            OP_BSUB:   begin c.kind = UPD_BREV; c.wb = 1'b1; c.use_idx = 1'b1; c.neg = 1'b1; end
            OP_OFS:    begin c.kind = UPD_OFS; end
            OP_PREOFS: begin c.kind = UPD_OFS;  c.wb = 1'b1; end
            default:   c.kind = UPD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addr_ptr_regfile.sv
module addr_ptr_regfile #(
    parameter int AW   = 16,
    parameter int NPTR = 8,
    localparam int SELW = $clog2(NPTR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [SELW:0]        ld_sel,
    input  logic [AW-1:0]        ld_data,
    input  logic                 up_en,
    input  logic [SELW-1:0]      up_sel,
    input  logic [AW-1:0]        up_data,
    output logic [NPTR*AW-1:0]   ptr_flat,
    output logic [AW-1:0]        size_q
);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [AW-1:0] ptr_q;
        logic          ld_hit;
        logic          up_hit;

        assign ld_hit = ld_en && (ld_sel == (SELW+1)'(g));
        assign up_hit = up_en && (up_sel == SELW'(g));

        // a load beats an access write-back on the same register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ptr_q <= '0;
            else if (ld_hit) ptr_q <= ld_data;
            else if (up_hit) ptr_q <= up_data;
        end

        assign ptr_flat[g*AW +: AW] = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            size_q <= '0;
        else if (ld_en && (ld_sel == (SELW+1)'(NPTR)))
            size_q <= ld_data;
    end

endmodule

// File: rtl/addr_ptr_circ.sv
module addr_ptr_circ #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] mag,
    input  logic          sub,
    input  logic [AW-1:0] size,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] blk_mask
);

    logic [AW-1:0] start;
    logic [AW-1:0] off;
    logic [AW-1:0] size_nz;
    logic [AW-1:0] red;
    logic [AW:0]   sum;
    logic [AW:0]   wrapped;

    // block mask: every bit at or below the length's top set bit
    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign blk_mask[i] = |size[AW-1:i];
    end

    assign start   = cur & ~blk_mask;
    assign off     = cur & blk_mask;
    assign size_nz = (size == '0) ? AW'(1) : size;
    assign red     = mag % size_nz;

    always_comb begin
        if (sub) begin
            if (off >= red) sum = {1'b0, off} - {1'b0, red};
            else            sum = {1'b0, off} + {1'b0, size} - {1'b0, red};
            wrapped = sum;
        end else begin
            sum = {1'b0, off} + {1'b0, red};
            if (sum >= {1'b0, size}) wrapped = sum - {1'b0, size};
            else                     wrapped = sum;
        end
        if (size == '0) nxt = sub ? (cur - mag) : (cur + mag);
        else            nxt = start | wrapped[AW-1:0];
    end

endmodule

// File: rtl/addr_ptr_brev.sv
module addr_ptr_brev #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] idx,
    input  logic          sub,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] rc;
    logic [AW-1:0] ri;
    logic [AW-1:0] rs;

    for (genvar i = 0; i < AW; i++) begin : g_rev
        assign rc[i]        = cur[AW-1-i];
        assign ri[i]        = idx[AW-1-i];
        assign nxt[AW-1-i]  = rs[i];
    end

    assign rs = sub ? (rc - ri) : (rc + ri);

endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
    import addr_ptr_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NPTR = 8,
    localparam int SELW = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [SELW:0]   ld_sel,
    input  logic [AW-1:0]   ld_data,
    input  logic            acc_en,
    input  logic [SELW-1:0] acc_sel,
    input  logic [3:0]      acc_op,
    input  logic [AW-1:0]   acc_k,
    output logic [AW-1:0]   addr_out,
    output logic            addr_vld
);

    logic [NPTR*AW-1:0] ptr_flat;
    logic [AW-1:0]      size_q;
    logic [AW-1:0]      cur;
    logic [AW-1:0]      idx;
    upd_ctl_t           ctl;
    logic [AW-1:0]      raw_step;
    logic               step_neg;
    logic [AW-1:0]      mag;
    logic               dir_sub;
    logic [AW-1:0]      lin_nxt;
    logic [AW-1:0]      k_sum;
    logic [AW-1:0]      circ_nxt;
    logic [AW-1:0]      blk_mask;
    logic [AW-1:0]      brev_nxt;
    logic [AW-1:0]      upd_val;
    logic [AW-1:0]      addr_d;
    logic               up_en;

    addr_ptr_regfile #(.AW(AW), .NPTR(NPTR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .up_en    (up_en),
        .up_sel   (acc_sel),
        .up_data  (upd_val),
        .ptr_flat (ptr_flat),
        .size_q   (size_q)
    );

    assign cur = ptr_flat[acc_sel*AW +: AW];
    assign idx = ptr_flat[AW-1:0];
    assign ctl = decode_op(acc_op);

    assign raw_step = ctl.use_idx ? idx : AW'(1);
    assign step_neg = ctl.use_idx & raw_step[AW-1];
    assign mag      = step_neg ? (~raw_step + AW'(1)) : raw_step;
    assign dir_sub  = ctl.neg ^ step_neg;
    assign lin_nxt  = ctl.neg ? (cur - raw_step) : (cur + raw_step);
    assign k_sum    = cur + acc_k;

    addr_ptr_circ #(.AW(AW)) u_circ (
        .cur      (cur),
        .mag      (mag),
        .sub      (dir_sub),
        .size     (size_q),
        .nxt      (circ_nxt),
        .blk_mask (blk_mask)
    );

    addr_ptr_brev #(.AW(AW)) u_brev (
        .cur (cur),
        .idx (idx),
        .sub (ctl.neg),
        .nxt (brev_nxt)
    );

    always_comb begin
        upd_val = cur;
        addr_d  = cur;
        unique case (ctl.kind)
            UPD_LIN:  upd_val = lin_nxt;
            UPD_CIRC: upd_val = circ_nxt;
            UPD_BREV: upd_val = brev_nxt;
            UPD_OFS:  begin upd_val = k_sum; addr_d = k_sum; end
            default:  upd_val = cur;
        endcase
    end

    assign up_en = acc_en && ctl.wb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_out <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= acc_en;
            if (acc_en) addr_out <= addr_d;
        end
    end

    a_r3_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_vld);

    a_r3_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !addr_vld);

    a_r3_post_uses_old: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && ctl.kind != UPD_OFS) |=> (addr_out == $past(ptr_flat[acc_sel*AW +: AW])));

    a_r2_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !ld_sel[SELW]) |=> (ptr_flat[$past(ld_sel[SELW-1:0])*AW +: AW] == $past(ld_data)));

    a_r6_stay_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && ctl.kind == UPD_CIRC && size_q != '0 && (cur & blk_mask) < size_q)
        |-> (((circ_nxt & ~blk_mask) == (cur & ~blk_mask)) && ((circ_nxt & blk_mask) < size_q)));

    a_r8_brev_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && ctl.kind == UPD_BREV && idx == '0) |-> (brev_nxt == cur));

    a_r10_keep_all: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && ctl.kind == UPD_NONE && !ld_en) |=> $stable(ptr_flat));

endmodule

// File: tb/tb_addr_ptr_unit.sv
module tb_addr_ptr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [3:0]  acc_op = '0;
    logic [15:0] acc_k = '0;
    logic [15:0] addr_out;
    logic        addr_vld;

    always #2.5 clk = ~clk;

    addr_ptr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .acc_en(acc_en), .acc_sel(acc_sel), .acc_op(acc_op), .acc_k(acc_k),
        .addr_out(addr_out), .addr_vld(addr_vld)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    int mp [8];
    int msz;
    int exp_addr;
    bit exp_vld;

    function automatic int rev16(input int v);
        int r = 0;
        for (int i = 0; i < 16; i++)
            if ((v >> i) & 1) r = r | (1 << (15 - i));
        return r;
    endfunction

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mp[i] = 0;
            msz = 0; exp_addr = 0; exp_vld = 0;
        end else begin
            int p, ix, sidx, np, ad, d, nb, blk, st, off;
            exp_vld = acc_en;
            exp_tag = cur_tag;
            p  = mp[acc_sel];
            ix = mp[0];
            sidx = (ix >= 32768) ? ix - 65536 : ix;
            np = p; ad = p;
            if (acc_en) begin
                case (int'(acc_op))
                    1: np = (p + 1) & 16'hFFFF;
                    2: np = (p - 1) & 16'hFFFF;
                    3: np = (p + ix) & 16'hFFFF;
                    4: np = (p - ix) & 16'hFFFF;
                    5, 6, 7, 8: begin
                        case (int'(acc_op))
                            5: d = 1;
                            6: d = -1;
                            7: d = sidx;
                            default: d = -sidx;
                        endcase
                        if (msz == 0) np = (p + d) & 16'hFFFF;
                        else begin
                            nb = 0;
                            while ((1 << nb) <= msz) nb++;
                            blk = 1 << nb;
                            off = p % blk;
                            st  = p - off;
                            np  = st + ((((off + d) % msz) + msz) % msz);
                        end
                    end
                    9:  np = rev16((rev16(p) + rev16(ix)) & 16'hFFFF);
                    10: np = rev16((rev16(p) - rev16(ix)) & 16'hFFFF);
                    11: ad = (p + int'(acc_k)) & 16'hFFFF;
                    12: begin ad = (p + int'(acc_k)) & 16'hFFFF; np = ad; end
                    default: np = p;
                endcase
                exp_addr = ad;
                mp[acc_sel] = np;
            end
            if (ld_en) begin
                if (ld_sel < 8) mp[ld_sel] = int'(ld_data);
                else if (ld_sel == 8) msz = int'(ld_data);
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (addr_vld !== exp_vld || (exp_vld && int'(addr_out) != exp_addr)) begin
                n_bad++;
                $display("FAIL %s: vld=%0b addr=%04h expected vld=%0b addr=%04h",
                         exp_tag, addr_vld, addr_out, exp_vld, exp_addr[15:0]);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            ld_en = 0; acc_en = 0;
        end
    endtask

    task automatic ld(input int sel, input int val);
        @(negedge clk);
        acc_en = 0; ld_en = 1; ld_sel = 4'(sel); ld_data = 16'(val);
    endtask

    task automatic acc(input int sel, input int op, input int k);
        @(negedge clk);
        ld_en = 0; acc_en = 1; acc_sel = 3'(sel); acc_op = 4'(op); acc_k = 16'(k);
    endtask

    task automatic ld_acc(input int lsel, input int val, input int sel, input int op);
        @(negedge clk);
        ld_en = 1; ld_sel = 4'(lsel); ld_data = 16'(val);
        acc_en = 1; acc_sel = 3'(sel); acc_op = 4'(op); acc_k = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        repeat (3) @(negedge clk);
        n_chk++;
        if (addr_vld !== 1'b0 || addr_out !== 16'h0) begin
            n_bad++;
            $display("FAIL R1: in reset vld=%0b addr=%04h expected vld=0 addr=0000", addr_vld, addr_out);
        end
        rst_n = 1;
        // R1: every pointer reads 0
        cur_tag = "R1";
        for (int i = 0; i < 8; i++) acc(i, 0, 0);
        idle(1);
        // R2: loads and load-vs-update priority
        cur_tag = "R2";
        ld(1, 16'h1000); ld(0, 2); acc(1, 0, 0);
        ld_acc(1, 16'h2000, 1, 1);
        acc(1, 0, 0);
        // R3 / R4: post-modify and linear wrap
        cur_tag = "R4";
        ld(3, 16'hFFFF);
        acc(3, 1, 0); acc(3, 0, 0); acc(3, 2, 0); acc(3, 3, 0); acc(3, 4, 0); acc(3, 4, 0);
        cur_tag = "R3";
        acc(3, 1, 0); idle(1); acc(3, 2, 0);
        // R5: length 30 (5-bit block) and 32 (6-bit block)
        cur_tag = "R5";
        ld(8, 30); ld(4, 16'h021C);
        acc(4, 5, 0); acc(4, 5, 0); acc(4, 6, 0); acc(4, 6, 0);
        ld(0, 3); acc(4, 7, 0); acc(4, 8, 0); acc(4, 8, 0);
        ld(8, 32); ld(5, 16'h045F);
        acc(5, 5, 0); acc(5, 6, 0); acc(5, 0, 0);
        // R6: negative index and step longer than the buffer
        cur_tag = "R6";
        ld(8, 30); ld(4, 16'h0201); ld(0, 16'hFFFE);
        acc(4, 7, 0); acc(4, 7, 0); acc(4, 8, 0);
        ld(0, 45); acc(4, 7, 0); acc(4, 7, 0); acc(4, 8, 0); acc(4, 0, 0);
        // R7: zero length acts linear
        cur_tag = "R7";
        ld(8, 0); ld(6, 16'hFFFF); ld(0, 5);
        acc(6, 5, 0); acc(6, 6, 0); acc(6, 8, 0); acc(6, 7, 0); acc(6, 0, 0);
        // R8: 16-point bit-reversed walk
        cur_tag = "R8";
        ld(0, 8); ld(5, 16'h0400);
        for (int i = 0; i < 17; i++) acc(5, 9, 0);
        for (int i = 0; i < 4; i++) acc(5, 10, 0);
        ld(0, 0); acc(5, 9, 0); acc(5, 0, 0);
        // R9: constant offset with and without write-back
        cur_tag = "R9";
        ld(2, 16'h0100);
        acc(2, 11, 16'h0010); acc(2, 0, 0); acc(2, 12, 16'hFFF0); acc(2, 0, 0);
        // R10: keep and unused codes
        cur_tag = "R10";
        ld(7, 16'h5A5A);
        acc(7, 0, 0); acc(7, 13, 16'h1111); acc(7, 14, 0); acc(7, 15, 0); acc(7, 0, 0);
        idle(1);
        // mixed traffic: circular pointers kept inside their buffers
        cur_tag = "R6";
        ld(8, 24); ld(0, 7);
        ld(4, 16'h0303); ld(5, 16'h052A); ld(6, 16'h0757); ld(7, 16'h0960);
        ld(1, 16'h1234); ld(2, 16'h8000); ld(3, 16'h00F0);
        rs = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            int sel, op;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            sel = int'(rs[2:0]);
            if (sel == 0) idle(1);
            else begin
                if (sel >= 4) op = 5 + int'(rs[9:8]);
                else op = (int'(rs[12:9]) == 5) ? 0 : int'(rs[12:9]);
                if (sel < 4 && op >= 5 && op <= 8) op = op - 4;
                acc(sel, op, int'(rs[31:16]));
            end
        end
        idle(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule